// File: doc/BRIEF.md
# Dual-Width Integer ALU with Byte-Order Conversion

This block is the execute-stage arithmetic unit of a 64-bit register machine. Each request carries an 8-bit opcode, the current destination register value, the source register value and a 32-bit immediate. The unit returns one 64-bit result per accepted request, plus a flag that marks an opcode it cannot execute. The low three opcode bits pick 32-bit or 64-bit execution. Bit 3 picks the second operand. The high nibble picks the operation.

Most operations finish in one cycle: the result is registered and appears in the cycle after acceptance. Unsigned division and remainder with a non-zero divisor run on an iterative restoring divider that produces one quotient bit per cycle. While the divider works, `in_ready` is low and any request offered on the input is not taken. The byte-order conversion operation reads its swap width (16, 32 or 64 bits) from the immediate. It works on the full destination value.

Top module: `xalu_core`

## Requirements
- R1: Opcode bits [2:0] = 3'b100 selects 32-bit mode: both operands are cut to their low 32 bits and the result is zero-extended to 64 bits, except for byte-order conversion. Bits [2:0] = 3'b111 selects 64-bit mode.
- R2: Opcode bit 3 = 1 takes the source register as second operand. Bit 3 = 0 takes the immediate, which is sign-extended to 64 bits in 64-bit mode.
- R3: Opcode bits [7:4] select ADD 0x0, SUB 0x1, MUL 0x2 (low half of the product), OR 0x4, AND 0x5, XOR 0xA and MOV 0xB (result = second operand). NEG 0x8 gives the two's-complement negation of the destination and ignores the second operand.
- R4: LSH 0x6, RSH 0x7 (logical) and ARSH 0xC (arithmetic, sign taken from bit 31 in 32-bit mode and bit 63 in 64-bit mode) use a shift amount masked to 5 bits in 32-bit mode and to 6 bits in 64-bit mode.
- R5: DIV 0x3 and MOD 0x9 are unsigned. With a non-zero divisor, `in_ready` is low from the cycle after acceptance until the result is presented. Every other accepted request has its result valid in the cycle after acceptance. Each accepted request gives exactly one single-cycle `out_valid` pulse.
- R6: DIV by zero gives 0. MOD by zero gives the destination operand unchanged (its low 32 bits, zero-extended, in 32-bit mode). Both complete in one cycle.
- R7: Code 0xD in 32-bit mode converts byte order on the full 64-bit destination. The swap width is the immediate value 16, 32 or 64. Bit 3 = 0 keeps the low bytes of that width and zero-extends them. Bit 3 = 1 reverses the bytes within that width and zero-extends the result.
- R8: Class bits other than 3'b100 and 3'b111, codes 0xE and 0xF, code 0xD in 64-bit mode, or a swap width other than 16/32/64 give a one-cycle response with `out_illegal` = 1 and `out_result` = 0.
- R9: During and directly after reset, `out_valid` = 0, `out_illegal` = 0 and `in_ready` = 1.
- R10: A request offered while `in_ready` is low is not taken and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 8 | Opcode: operation [7:4], operand select [3], class [2:0] |
| in_dst | input | 64 | Destination register value |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Immediate |
| out_valid | output | 1 | Result valid pulse |
| out_result | output | 64 | Result |
| out_illegal | output | 1 | Request could not be executed |

## Verification
The case that matters most is a new request offered in the same cycles as a running division. The bench starts a 64-bit divide and then holds `in_valid` high with an ADD for twenty cycles while the divider is busy. It expects `in_ready` to be low in the cycle after acceptance, no `out_valid` while the divider runs, and then a single pulse that carries the quotient rather than the sum. The results of every other request are compared against a bench model over directed corner cases and seeded random opcodes in both widths. The bench also checks that one-cycle operations show no added latency.

// File: rtl/xalu_pkg.sv
package xalu_pkg;

  localparam logic [2:0] CLS_NARROW = 3'b100;
  localparam logic [2:0] CLS_WIDE   = 3'b111;

  localparam logic [3:0] OPC_ADD  = 4'h0;
  localparam logic [3:0] OPC_SUB  = 4'h1;
  localparam logic [3:0] OPC_MUL  = 4'h2;
  localparam logic [3:0] OPC_DIV  = 4'h3;
  localparam logic [3:0] OPC_OR   = 4'h4;
  localparam logic [3:0] OPC_AND  = 4'h5;
  localparam logic [3:0] OPC_LSH  = 4'h6;
  localparam logic [3:0] OPC_RSH  = 4'h7;
  localparam logic [3:0] OPC_NEG  = 4'h8;
  localparam logic [3:0] OPC_MOD  = 4'h9;
  localparam logic [3:0] OPC_XOR  = 4'hA;
  localparam logic [3:0] OPC_MOV  = 4'hB;
  localparam logic [3:0] OPC_ARSH = 4'hC;
  localparam logic [3:0] OPC_SWAP = 4'hD;

  localparam int SWAP_IDX_W = 3;

  typedef struct packed {
    logic                  legal;
    logic                  narrow;
    logic                  use_reg;
    logic [3:0]            code;
    logic                  long_op;
    logic                  swap_be;
    logic [SWAP_IDX_W-1:0] swap_idx;
  } xalu_dec_t;

endpackage

// File: rtl/xalu_decode.sv
module xalu_decode
  import xalu_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 32
) (
  input  logic [7:0]       op,
  input  logic [IMM_W-1:0] imm,
  output xalu_dec_t        dec
);
  localparam int NSWAP = $clog2(W / 16) + 1;

  logic cls_ok;
  logic code_ok;
  logic width_ok;

  always_comb begin
    dec          = '0;
    dec.code     = op[7:4];
    dec.use_reg  = op[3];
    dec.swap_be  = op[3];
    dec.narrow   = (op[2:0] == CLS_NARROW);
    cls_ok       = dec.narrow || (op[2:0] == CLS_WIDE);
    code_ok      = (op[7:4] <= OPC_SWAP);
    width_ok     = 1'b0;
    for (int g = 0; g < NSWAP; g++) begin
      if (imm == IMM_W'(16 << g)) begin
        width_ok     = 1'b1;
        dec.swap_idx = SWAP_IDX_W'(g);
      end
    end
    dec.long_op  = (op[7:4] == OPC_DIV) || (op[7:4] == OPC_MOD);
    dec.legal    = cls_ok && code_ok &&
                   ((op[7:4] != OPC_SWAP) || (dec.narrow && width_ok));
  end
endmodule

// File: rtl/xalu_exec.sv
module xalu_exec
  import xalu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   code,
  input  logic         narrow,
  output logic [W-1:0] res
);
  localparam int H   = W / 2;
  localparam int SHW = $clog2(W);

  logic [SHW-1:0] sh;
  logic [H-1:0]   ars_half;
  logic [W-1:0]   ars_full;
  logic [W-1:0]   raw;

  always_comb begin
    sh       = narrow ? {1'b0, b[SHW-2:0]} : b[SHW-1:0];
    ars_half = $signed(a[H-1:0]) >>> sh;
    ars_full = $signed(a) >>> sh;
    case (code)
      OPC_ADD:  raw = a + b;
      OPC_SUB:  raw = a - b;
      OPC_MUL:  raw = a * b;
      OPC_OR:   raw = a | b;
      OPC_AND:  raw = a & b;
      OPC_XOR:  raw = a ^ b;
      OPC_MOV:  raw = b;
      OPC_NEG:  raw = '0 - a;
      OPC_LSH:  raw = a << sh;
      OPC_RSH:  raw = a >> sh;
      OPC_ARSH: raw = narrow ? {{H{1'b0}}, ars_half} : ars_full;
      default:  raw = '0;
    endcase
    res = narrow ? {{H{1'b0}}, raw[H-1:0]} : raw;
  end
endmodule

// File: rtl/xalu_swap.sv
module xalu_swap
  import xalu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0]            data,
  input  logic [SWAP_IDX_W-1:0]   idx,
  input  logic                    be,
  output logic [W-1:0]            res
);
  localparam int NSWAP = $clog2(W / 16) + 1;

  logic [W-1:0] cand [NSWAP];

  for (genvar g = 0; g < NSWAP; g++) begin : g_width
    localparam int SW = 16 << g;
    localparam int NB = SW / 8;
    logic [SW-1:0] rev;
    for (genvar k = 0; k < NB; k++) begin : g_byte
      assign rev[k*8 +: 8] = data[(NB-1-k)*8 +: 8];
    end
    assign cand[g] = be ? W'(rev) : W'(data[SW-1:0]);
  end

  always_comb begin
    res = '0;
    for (int g = 0; g < NSWAP; g++) begin
      if (idx == SWAP_IDX_W'(g)) res = cand[g];
    end
  end
endmodule

// File: rtl/xalu_divider.sv
module xalu_divider #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic [W-1:0]  dvs;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    trial = {rem, quot[W-1]};
    diff  = trial - {1'b0, dvs};
    fits  = ~diff[W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      dvs  <= '0;
      quot <= '0;
      rem  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        cnt  <= '0;
        dvs  <= divisor;
        quot <= dividend;
        rem  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? diff[W-1:0] : trial[W-1:0];
        quot <= {quot[W-2:0], fits};
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xalu_core.sv
module xalu_core
  import xalu_pkg::*;
#(
  parameter int W     = 64,
  parameter int IMM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_op,
  input  logic [W-1:0]     in_dst,
  input  logic [W-1:0]     in_src,
  input  logic [IMM_W-1:0] in_imm,
  output logic             out_valid,
  output logic [W-1:0]     out_result,
  output logic             out_illegal
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LO_MASK = {{H{1'b0}}, {H{1'b1}}};

  xalu_dec_t    dec;
  logic [W-1:0] imm_ext;
  logic [W-1:0] a_op;
  logic [W-1:0] b_op;
  logic [W-1:0] alu_res;
  logic [W-1:0] swap_res;
  logic [W-1:0] fast_res;
  logic         accept;
  logic         div_zero;
  logic         div_start;
  logic         div_busy;
  logic         div_done;
  logic [W-1:0] div_quot;
  logic [W-1:0] div_rem;
  logic         pend;
  logic         pend_mod;

  xalu_decode #(.W(W), .IMM_W(IMM_W)) u_dec (
    .op  (in_op),
    .imm (in_imm),
    .dec (dec)
  );

  always_comb begin
    imm_ext  = {{(W-IMM_W){in_imm[IMM_W-1]}}, in_imm};
    a_op     = dec.narrow ? (in_dst & LO_MASK) : in_dst;
    b_op     = dec.use_reg ? in_src : imm_ext;
    if (dec.narrow) b_op = b_op & LO_MASK;
    div_zero = (b_op == '0);
  end

  xalu_exec #(.W(W)) u_exec (
    .a      (a_op),
    .b      (b_op),
    .code   (dec.code),
    .narrow (dec.narrow),
    .res    (alu_res)
  );

  xalu_swap #(.W(W)) u_swap (
    .data (in_dst),
    .idx  (dec.swap_idx),
    .be   (dec.swap_be),
    .res  (swap_res)
  );

  always_comb begin
    case (dec.code)
      OPC_SWAP: fast_res = swap_res;
      OPC_DIV:  fast_res = '0;
      OPC_MOD:  fast_res = a_op;
      default:  fast_res = alu_res;
    endcase
  end

  assign in_ready  = ~pend;
  assign accept    = in_valid & in_ready;
  assign div_start = accept & dec.legal & dec.long_op & ~div_zero;

  xalu_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (a_op),
    .divisor  (b_op),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_quot),
    .rem      (div_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
      pend        <= 1'b0;
      pend_mod    <= 1'b0;
    end else begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      if (accept) begin
        if (!dec.legal) begin
          out_valid   <= 1'b1;
          out_illegal <= 1'b1;
          out_result  <= '0;
        end else if (div_start) begin
          pend     <= 1'b1;
          pend_mod <= (dec.code == OPC_MOD);
        end else begin
          out_valid  <= 1'b1;
          out_result <= fast_res;
        end
      end
      if (pend && div_done && !div_busy) begin
        pend       <= 1'b0;
        out_valid  <= 1'b1;
        out_result <= pend_mod ? div_rem : div_quot;
      end
    end
  end
endmodule

// File: rtl/xalu_core_chk.sv
module xalu_core_chk #(
  parameter int W     = 64,
  parameter int IMM_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_op,
  input logic [W-1:0]     in_src,
  input logic [IMM_W-1:0] in_imm,
  input logic             out_valid,
  input logic [W-1:0]     out_result,
  input logic             out_illegal
);
  localparam int H = W / 2;

  logic         take;
  logic         cls32;
  logic         cls_good;
  logic [W-1:0] dvsr;
  logic         slow;
  logic         cap_narrow;

  always_comb begin
    take     = in_valid && in_ready;
    cls32    = (in_op[2:0] == 3'b100);
    cls_good = cls32 || (in_op[2:0] == 3'b111);
    dvsr     = in_op[3] ? in_src : {{(W-IMM_W){in_imm[IMM_W-1]}}, in_imm};
    if (cls32) dvsr[W-1:H] = '0;
    slow     = cls_good && ((in_op[7:4] == 4'h3) || (in_op[7:4] == 4'h9)) &&
               (dvsr != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) cap_narrow <= 1'b0;
    else if (take) cap_narrow <= cls32 && (in_op[7:4] != 4'hD);
  end

  assert_narrow_zext_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && cap_narrow) |-> (out_result[W-1:H] == '0));

  assert_fast_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (take && !slow) |=> out_valid);

  assert_slow_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (take && slow) |=> (!in_ready && !out_valid));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !take) |=> !out_valid);

  assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_valid && out_result == '0));

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !out_illegal && in_ready));
endmodule

bind xalu_core xalu_core_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_op       (in_op),
  .in_src      (in_src),
  .in_imm      (in_imm),
  .out_valid   (out_valid),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/xalu_core_test.sv
`timescale 1ns/1ps
module xalu_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_op = '0;
  logic [63:0] in_dst = '0;
  logic [63:0] in_src = '0;
  logic [31:0] in_imm = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_illegal;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  xalu_core uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src(in_src), .in_imm(in_imm),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  // Reference: returns {illegal, result}
  function automatic logic [64:0] model(input logic [7:0] op, input logic [63:0] d,
                                        input logic [63:0] s, input logic [31:0] imm);
    logic n32, ok;
    logic [63:0] a, b, r;
    int sh, w;
    n32 = (op[2:0] == 3'd4);
    ok  = n32 || (op[2:0] == 3'd7);
    a   = n32 ? {32'd0, d[31:0]} : d;
    b   = op[3] ? s : {{32{imm[31]}}, imm};
    if (n32) b = {32'd0, b[31:0]};
    sh  = n32 ? int'(b[4:0]) : int'(b[5:0]);
    r   = '0;
    case (op[7:4])
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 64'd0 : a / b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << sh;
      4'h7: r = a >> sh;
      4'h8: r = 64'd0 - a;
      4'h9: r = (b == 0) ? a : a % b;
      4'hA: r = a ^ b;
      4'hB: r = b;
      4'hC: begin
        if (n32) begin
          r = {32'd0, 32'($signed(a[31:0]) >>> sh)};
        end else begin
          r = $signed(a) >>> sh;
        end
      end
      4'hD: begin
        w = int'(imm);
        if (!n32 || !(w == 16 || w == 32 || w == 64)) ok = 1'b0;
        else if (!op[3]) r = (w == 64) ? d : (d & ((64'd1 << w) - 1));
        else for (int k = 0; k < w / 8; k++) r[k*8 +: 8] = d[(w/8-1-k)*8 +: 8];
      end
      default: ok = 1'b0;
    endcase
    if (n32 && op[7:4] != 4'hD) r = {32'd0, r[31:0]};
    if (!ok) r = '0;
    return {~ok, r};
  endfunction

  function automatic logic is_slow(input logic [7:0] op, input logic [63:0] s,
                                   input logic [31:0] imm);
    logic [63:0] b;
    b = op[3] ? s : {{32{imm[31]}}, imm};
    if (op[2:0] == 3'd4) b = {32'd0, b[31:0]};
    return (op[2:0] == 3'd4 || op[2:0] == 3'd7) &&
           (op[7:4] == 4'h3 || op[7:4] == 4'h9) && (b != 0);
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    if (!(op[2:0] == 3'd4 || op[2:0] == 3'd7) || op[7:4] > 4'hD) return "R8";
    case (op[7:4])
      4'h3, 4'h9: return "R5";
      4'h6, 4'h7, 4'hC: return "R4";
      4'hD: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Called at a negedge; returns at a negedge.
  task automatic run_op(input logic [7:0] op, input logic [63:0] d, input logic [63:0] s,
                        input logic [31:0] imm, input string req);
    logic [64:0] e;
    int lat;
    e = model(op, d, s, imm);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_dst = d; in_src = s; in_imm = imm;
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, out_result, e[63:0]);
    check({req, " illegal"}, 64'(out_illegal), 64'(e[64]));
    if (!is_slow(op, s, imm)) check("R5 fast latency", 64'(lat), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R5 watchdog expired got=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 out_valid", 64'(out_valid), 64'd0);
    check("R9 out_illegal", 64'(out_illegal), 64'd0);
    check("R9 in_ready", 64'(in_ready), 64'd1);

    // R1 narrow truncation and zero-extension
    run_op(8'h0C, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0, "R1");
    run_op(8'h0F, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0, "R1");
    // R2 immediate sign extension vs truncation
    run_op(8'hB7, 64'd5, 64'd9, 32'h8000_0000, "R2");
    run_op(8'hB4, 64'd5, 64'd9, 32'h8000_0000, "R2");
    run_op(8'hBF, 64'd5, 64'h1234_5678_9ABC_DEF0, 32'h8000_0000, "R2");
    // R3 NEG ignores operand
    run_op(8'h8F, 64'd7, 64'hDEAD, 32'd99, "R3");
    run_op(8'h84, 64'd7, 64'hDEAD, 32'd99, "R3");
    run_op(8'h27, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 32'hFFFF_FFFF, "R3");
    // R4 shift masks and arithmetic shifts
    run_op(8'h64, 64'h1, 64'd0, 32'd33, "R4");
    run_op(8'h67, 64'h1, 64'd0, 32'd65, "R4");
    run_op(8'hC4, 64'h8000_0000, 64'd0, 32'd4, "R4");
    run_op(8'hC7, 64'h8000_0000_0000_0000, 64'd0, 32'd63, "R4");
    run_op(8'h74, 64'hFFFF_FFFF_8000_0000, 64'd0, 32'd31, "R4");
    // R5 unsigned divide/remainder
    run_op(8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, "R5");
    run_op(8'h9C, 64'h0000_0007_FFFF_FFFE, 64'h1_0000_0007, 0, "R5");
    run_op(8'h37, 64'd100, 64'd0, 32'hFFFF_FFFF, "R5");
    // R6 divide by zero
    run_op(8'h37, 64'd1234, 64'd5, 32'd0, "R6");
    run_op(8'h9F, 64'hAAAA_BBBB_CCCC_DDDD, 64'd0, 32'd7, "R6");
    run_op(8'h9C, 64'hAAAA_BBBB_CCCC_DDDD, 64'h1_0000_0000, 32'd7, "R6");
    // R7 byte-order conversion on full destination
    run_op(8'hD4, 64'h0102_0304_0506_0708, 64'd0, 32'd16, "R7");
    run_op(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd16, "R7");
    run_op(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd32, "R7");
    run_op(8'hDC, 64'h0102_0304_0506_0708, 64'd0, 32'd64, "R7");
    run_op(8'hD4, 64'h0102_0304_0506_0708, 64'd0, 32'd64, "R7");
    // R8 illegal forms
    run_op(8'hD7, 64'h0102_0304_0506_0708, 64'd0, 32'd16, "R8");
    run_op(8'hD4, 64'h0102_0304_0506_0708, 64'd0, 32'd8, "R8");
    run_op(8'hE7, 64'd1, 64'd2, 32'd3, "R8");
    run_op(8'h05, 64'd1, 64'd2, 32'd3, "R8");
    run_op(8'h31, 64'd10, 64'd2, 32'd3, "R8");

    // R10 request offered during a divide is not taken
    begin
      int pulses;
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_op = 8'h3F; in_dst = 64'd1000; in_src = 64'd7; in_imm = 0;
      @(negedge clk);
      check("R5 ready low after divide start", 64'(in_ready), 64'd0);
      in_op = 8'h0F; in_dst = 64'd1; in_src = 64'd1;
      pulses = 0;
      for (int i = 0; i < 20; i++) begin
        if (out_valid) pulses++;
        @(negedge clk);
      end
      in_valid = 1'b0;
      check("R10 no result while busy", 64'(pulses), 64'd0);
      for (int i = 0; i < 200 && !out_valid; i++) @(negedge clk);
      check("R10 divide result", out_result, 64'd142);
      pulses = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (out_valid) pulses++;
      end
      check("R10 no extra result", 64'(pulses), 64'd0);
    end

    // Random mix, both widths
    for (int n = 0; n < 1200; n++) begin
      logic [7:0]  op;
      logic [63:0] d, s;
      logic [31:0] imm;
      int sel;
      op[7:4] = 4'($urandom_range(0, 15));
      op[3]   = 1'($urandom);
      sel     = $urandom_range(0, 9);
      op[2:0] = (sel == 0) ? 3'($urandom) : ((sel < 5) ? 3'd4 : 3'd7);
      d   = {$urandom, $urandom};
      s   = ($urandom_range(0, 7) == 0) ? 64'd0 : {$urandom, $urandom};
      imm = ($urandom_range(0, 5) == 0) ? 32'd0 : $urandom;
      if (op[7:4] == 4'hD) begin
        sel = $urandom_range(0, 3);
        imm = (sel == 0) ? 32'd16 : (sel == 1) ? 32'd32 : (sel == 2) ? 32'd64 : $urandom;
      end
      run_op(op, d, s, imm, tag_of(op));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule